// File: doc/BRIEF.md
# Sign-Magnitude Sequential Divider

This block divides a sign-magnitude dividend of double length by a sign-magnitude divisor of single length. It uses one shift-and-subtract step per clock. The dividend magnitude has 2N bits and the divisor magnitude has N bits. The result is an N-bit quotient magnitude and an N-bit remainder magnitude, each with its own sign.

Before any iteration starts, the block compares the upper half of the dividend against the divisor. If the upper half is equal to or larger than the divisor, the quotient cannot fit in N bits. In that case the block raises a divide-overflow flag and finishes at once. A divisor of zero always falls into this case.

A mode input selects how each step handles a negative trial remainder. In restoring mode the previous partial remainder is kept. In non-restoring mode the negative value is carried into the next step, which then adds the divisor instead of subtracting it. Non-restoring mode ends with one correction addition when the remainder is still negative. Both modes take the same number of cycles and give the same results.

Top module: `sm_divider`

## Requirements
- R1: After reset, done, ovf, quo_sign, rem_sign, quo_mag and rem_mag are all 0.
- R2: A start accepted while idle, with dvd_mag[2N-1:N] >= dvs_mag, sets ovf=1, clears quo_mag and rem_mag to 0, and raises done in the very next cycle.
- R3: A divisor magnitude of zero always produces the overflow outcome of R2, whatever the dividend.
- R4: With nonrest_mode=0 and no overflow, quo_mag equals floor(dvd_mag/dvs_mag) and rem_mag equals dvd_mag mod dvs_mag when done rises. rem_mag is always below dvs_mag.
- R5: With nonrest_mode=1 and no overflow, the results equal those of R4. This includes the final correction of a negative remainder.
- R6: For a start sampled at clock edge k without overflow, done is high only in the cycle after edge k+N+1, in both modes.
- R7: done is high for exactly one cycle per accepted start.
- R8: quo_sign equals dvd_sign XOR dvs_sign, and rem_sign equals dvd_sign. Both are captured at the accepted start, and they also apply on overflow.
- R9: After done, ovf, quo_mag, rem_mag and the signs hold until the next accepted start. A start raised while a division is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a division; accepted only when idle |
| nonrest_mode | input | 1 | 0 = restoring steps, 1 = non-restoring steps |
| dvd_sign | input | 1 | Dividend sign (1 = negative) |
| dvd_mag | input | 2N | Dividend magnitude; upper half is the overflow-check half |
| dvs_sign | input | 1 | Divisor sign |
| dvs_mag | input | N | Divisor magnitude |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Divide overflow, valid from done until next start |
| quo_sign | output | 1 | Quotient sign |
| quo_mag | output | N | Quotient magnitude |
| rem_sign | output | 1 | Remainder sign |
| rem_mag | output | N | Remainder magnitude |

## Verification
Each step feeds its partial remainder and shifted quotient bit into the next step. A wrong add/subtract choice, a missing restore or a skipped correction therefore changes quo_mag or rem_mag by the cycle after done. The reference model compares these outputs in that cycle. A miscounted step counter moves the done pulse off the exact cycle N+2 after the start edge, and the bench sees this at once. A wrong overflow comparison shows up one cycle after start, as ovf or a done pulse arriving too early or too late. The operand patterns include the boundary cases: an upper half equal to the divisor, an upper half one below the divisor, and a divisor of one.

// File: rtl/sm_div_pkg.sv
package sm_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;
endpackage

// File: rtl/sm_div_rst_sync.sv
module sm_div_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sm_div_step.sv
// One iteration: shift partial remainder left with the next dividend bit,
// then subtract (or, non-restoring with a negative remainder, add) divisor.
module sm_div_step #(
  parameter int N = 8
) (
  input  logic signed [N:0] rem_i,
  input  logic              q_msb_i,
  input  logic [N-1:0]      dvs_i,
  input  logic              nonrest_i,
  output logic signed [N:0] rem_o,
  output logic              q_bit_o
);
  localparam int TW = N + 2;

  logic signed [TW-1:0] shifted;
  logic signed [TW-1:0] dvs_ext;
  logic signed [TW-1:0] diff;
  logic signed [TW-1:0] sum;
  logic signed [TW-1:0] pick;

  always_comb begin
    shifted = {rem_i, q_msb_i};
    dvs_ext = {2'b00, dvs_i};
    diff    = shifted - dvs_ext;
    sum     = shifted + dvs_ext;
    if (nonrest_i && rem_i[N]) pick = sum;
    else                       pick = diff;
    if (!nonrest_i && pick[TW-1]) begin
      // restore: keep the shifted value, which is below the divisor
      rem_o   = shifted[N:0];
      q_bit_o = 1'b0;
    end else begin
      rem_o   = pick[N:0];
      q_bit_o = ~pick[TW-1];
    end
  end
endmodule

// File: rtl/sm_div_fix.sv
// Final correction: a negative partial remainder gets the divisor added once.
module sm_div_fix #(
  parameter int N = 8
) (
  input  logic signed [N:0] rem_i,
  input  logic [N-1:0]      dvs_i,
  output logic [N-1:0]      rem_o
);
  logic signed [N:0] corrected;

  always_comb begin
    if (rem_i[N]) corrected = rem_i + {1'b0, dvs_i};
    else          corrected = rem_i;
    rem_o = corrected[N-1:0];
  end
endmodule

// File: rtl/sm_div_ctrl.sv
module sm_div_ctrl
  import sm_div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       ovf_hit_i,
  output div_state_e state_o,
  output logic       accept_o,
  output logic       step_o,
  output logic       fin_o,
  output logic       done_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  div_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           done_q, done_d;
  logic           cnt_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    accept_o = 1'b0;
    step_o   = 1'b0;
    fin_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          if (ovf_hit_i) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
        else               cnt_d   = cnt_q + 1'b1;
      end
      ST_FIN: begin
        fin_o   = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_en = accept_o | step_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sm_divider.sv
module sm_divider
  import sm_div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           nonrest_mode,
  input  logic           dvd_sign,
  input  logic [2*N-1:0] dvd_mag,
  input  logic           dvs_sign,
  input  logic [N-1:0]   dvs_mag,
  output logic           done,
  output logic           ovf,
  output logic           quo_sign,
  output logic [N-1:0]   quo_mag,
  output logic           rem_sign,
  output logic [N-1:0]   rem_mag
);
  logic              rst_n_int;
  div_state_e        state;
  logic              idle;
  logic              accept, step, fin;
  logic              ovf_hit;
  logic [N-1:0]      dvd_hi, dvd_lo;

  logic signed [N:0] rem_q, rem_d;
  logic [N-1:0]      quo_q, quo_d;
  logic [N-1:0]      dvs_q, dvs_d;
  logic              mode_q, mode_d;
  logic              qs_q, qs_d, rs_q, rs_d, ovf_q, ovf_d;
  logic              data_en;

  logic signed [N:0] step_rem;
  logic              step_qbit;
  logic [N-1:0]      fix_rem;

  sm_div_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_an     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign dvd_hi  = dvd_mag[2*N-1:N];
  assign dvd_lo  = dvd_mag[N-1:0];
  assign ovf_hit = (dvs_mag == '0) || (dvd_hi >= dvs_mag);

  sm_div_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start_i   (start),
    .ovf_hit_i (ovf_hit),
    .state_o   (state),
    .accept_o  (accept),
    .step_o    (step),
    .fin_o     (fin),
    .done_o    (done)
  );

  assign idle = (state == ST_IDLE);

  sm_div_step #(.N(N)) u_step (
    .rem_i     (rem_q),
    .q_msb_i   (quo_q[N-1]),
    .dvs_i     (dvs_q),
    .nonrest_i (mode_q),
    .rem_o     (step_rem),
    .q_bit_o   (step_qbit)
  );

  sm_div_fix #(.N(N)) u_fix (
    .rem_i (rem_q),
    .dvs_i (dvs_q),
    .rem_o (fix_rem)
  );

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    mode_d = mode_q;
    qs_d   = qs_q;
    rs_d   = rs_q;
    ovf_d  = ovf_q;
    if (accept) begin
      dvs_d  = dvs_mag;
      mode_d = nonrest_mode;
      qs_d   = dvd_sign ^ dvs_sign;
      rs_d   = dvd_sign;
      if (ovf_hit) begin
        ovf_d = 1'b1;
        rem_d = '0;
        quo_d = '0;
      end else begin
        ovf_d = 1'b0;
        rem_d = {1'b0, dvd_hi};
        quo_d = dvd_lo;
      end
    end else if (step) begin
      rem_d = step_rem;
      quo_d = {quo_q[N-2:0], step_qbit};
    end else if (fin) begin
      rem_d = {1'b0, fix_rem};
    end
  end

  assign data_en = accept | step | fin;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      mode_q <= 1'b0;
      qs_q   <= 1'b0;
      rs_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (data_en) begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      mode_q <= mode_d;
      qs_q   <= qs_d;
      rs_q   <= rs_d;
      ovf_q  <= ovf_d;
    end
  end

  assign ovf      = ovf_q;
  assign quo_sign = qs_q;
  assign rem_sign = rs_q;
  assign quo_mag  = quo_q;
  assign rem_mag  = rem_q[N-1:0];
endmodule

// File: rtl/sm_divider_chk.sv
module sm_divider_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           idle,
  input logic           start,
  input logic           dvd_sign,
  input logic [2*N-1:0] dvd_mag,
  input logic           dvs_sign,
  input logic [N-1:0]   dvs_mag,
  input logic           done,
  input logic           ovf,
  input logic           quo_sign,
  input logic [N-1:0]   quo_mag,
  input logic           rem_sign,
  input logic [N-1:0]   rem_mag
);
  localparam int LW = $clog2(N + 2) + 1;

  logic          acc, big_hi;
  logic [LW-1:0] lat_q;
  logic          cap_ds, cap_vs;
  logic [N-1:0]  cap_dvs;

  assign acc    = start && idle;
  assign big_hi = dvd_mag[2*N-1:N] >= dvs_mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= '0;
      cap_ds  <= 1'b0;
      cap_vs  <= 1'b0;
      cap_dvs <= '0;
    end else begin
      if (acc) begin
        cap_ds  <= dvd_sign;
        cap_vs  <= dvs_sign;
        cap_dvs <= dvs_mag;
        lat_q   <= big_hi ? '0 : LW'(N + 1);
      end else if (lat_q != '0) begin
        lat_q <= lat_q - 1'b1;
      end
    end
  end

  AST_OVF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && big_hi |=> ovf && done && quo_mag == '0 && rem_mag == '0); // R2
  AST_OVF_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && dvs_mag == '0 |=> ovf && done); // R3
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ovf |-> rem_mag < cap_dvs); // R4
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q == LW'(1) |=> done); // R6
  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q > LW'(1) |-> !done); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_SIGNS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> quo_sign == (cap_ds ^ cap_vs) && rem_sign == cap_ds); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle && !start |=> $stable(quo_mag) && $stable(rem_mag) && $stable(ovf)); // R9
endmodule

bind sm_divider sm_divider_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .idle     (idle),
  .start    (start),
  .dvd_sign (dvd_sign),
  .dvd_mag  (dvd_mag),
  .dvs_sign (dvs_sign),
  .dvs_mag  (dvs_mag),
  .done     (done),
  .ovf      (ovf),
  .quo_sign (quo_sign),
  .quo_mag  (quo_mag),
  .rem_sign (rem_sign),
  .rem_mag  (rem_mag)
);

// File: tb/sm_divider_test.sv
`timescale 1ns/1ps
module sm_divider_test;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           nonrest_mode = 1'b0;
  logic           dvd_sign = 1'b0;
  logic [2*N-1:0] dvd_mag = '0;
  logic           dvs_sign = 1'b0;
  logic [N-1:0]   dvs_mag = '0;
  logic           done, ovf, quo_sign, rem_sign;
  logic [N-1:0]   quo_mag, rem_mag;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sm_divider #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .nonrest_mode(nonrest_mode),
    .dvd_sign(dvd_sign), .dvd_mag(dvd_mag), .dvs_sign(dvs_sign), .dvs_mag(dvs_mag),
    .done(done), .ovf(ovf), .quo_sign(quo_sign), .quo_mag(quo_mag),
    .rem_sign(rem_sign), .rem_mag(rem_mag)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int    m_cnt = 0;
  bit    m_done = 0, m_ovf = 0, m_qs = 0, m_rs = 0, m_valid = 1;
  int    m_q = 0, m_r = 0, p_q = 0, p_r = 0;
  string m_tag = "R1";
  bit    model_on = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_ovf = 0; m_qs = 0; m_rs = 0;
      m_valid = 1; m_q = 0; m_r = 0; m_tag = "R1";
    end else if (model_on) begin
      m_done = 0;
      if (m_cnt != 0) begin
        if (m_cnt == 1) begin
          m_done = 1; m_valid = 1; m_q = p_q; m_r = p_r;
        end
        m_cnt--;
      end else if (start) begin
        m_qs = dvd_sign ^ dvs_sign;
        m_rs = dvd_sign;
        if (dvs_mag == 0 || int'(dvd_mag[2*N-1:N]) >= int'(dvs_mag)) begin
          m_ovf = 1; m_done = 1; m_valid = 1; m_q = 0; m_r = 0;
          m_tag = (dvs_mag == 0) ? "R3" : "R2";
        end else begin
          m_ovf = 0; m_valid = 0;
          p_q = int'(dvd_mag) / int'(dvs_mag);
          p_r = int'(dvd_mag) % int'(dvs_mag);
          m_cnt = N + 1;
          m_tag = nonrest_mode ? "R5" : "R4";
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check(done == m_done, "R6 R7", "done", done, m_done);
      check(ovf == m_ovf, m_tag, "ovf", ovf, m_ovf);
      if (m_valid) begin
        check(quo_mag == m_q, m_tag, "quotient", quo_mag, m_q);
        check(rem_mag == m_r, m_tag, "remainder", rem_mag, m_r);
        check(quo_sign == m_qs, "R8", "quo_sign", quo_sign, m_qs);
        check(rem_sign == m_rs, "R8", "rem_sign", rem_sign, m_rs);
      end
    end
  end

  task automatic op(input bit mode, input bit ds, input int dvd, input bit vs, input int dvs);
    @(negedge clk);
    start = 1'b1; nonrest_mode = mode; dvd_sign = ds; dvd_mag = dvd[2*N-1:0];
    dvs_sign = vs; dvs_mag = dvs[N-1:0];
    @(negedge clk);
    start = 1'b0;
    repeat (N + 3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 0 && ovf == 0 && quo_mag == 0 && rem_mag == 0 && quo_sign == 0 && rem_sign == 0,
          "R1", "reset state", {done, ovf, quo_sign, rem_sign, quo_mag, rem_mag}, 0);
    model_on = 1;

    for (int m = 0; m < 2; m++) begin
      op(m[0], 0, 100, 0, 7);          // R4 / R5 basic
      op(m[0], 1, 77, 0, 5);           // R8 mixed signs
      op(m[0], 1, 1000, 1, 9);
      op(m[0], 0, 16'h00FF, 0, 1);     // divisor one
      op(m[0], 0, 16'hFEFF, 0, 255);   // upper half one below divisor
      op(m[0], 0, 0, 0, 3);            // zero dividend
      op(m[0], 0, 16'h0500, 0, 5);     // R2 upper half equals divisor
      op(m[0], 1, 16'h1234, 1, 0);     // R3 zero divisor
      op(m[0], 0, 16'hFFFF, 0, 16);    // R2 large
    end

    // R9: start during a running division is ignored
    @(negedge clk);
    start = 1'b1; nonrest_mode = 1'b0; dvd_sign = 0; dvd_mag = 16'd200; dvs_sign = 0; dvs_mag = 8'd9;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; dvd_mag = 16'hFFFF; dvs_mag = 8'd0; dvd_sign = 1;
    @(negedge clk);
    start = 1'b0;
    repeat (N + 4) @(negedge clk);
    check(quo_mag == 22 && rem_mag == 2 && ovf == 0, "R9", "busy start ignored",
          {ovf, quo_mag, rem_mag}, {1'b0, 8'd22, 8'd2});
    check(rem_sign == 0, "R9", "sign kept", rem_sign, 0);

    for (int i = 0; i < 400; i++) begin
      int dv, hi, lo;
      dv = 1 + ($urandom % 255);
      hi = (i % 7 == 0) ? (dv + ($urandom % (256 - dv))) : ($urandom % dv);
      lo = $urandom % 256;
      op(i[0], $urandom % 2 == 1, (hi << 8) | lo, $urandom % 2 == 1, dv);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R6 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule